// File: doc/BRIEF.md
# Shaped Phase-Reversal BPSK Carrier Generator

This block produces an 8-bit offset-binary sample stream for a DAC that carries a binary phase-shift keyed audio carrier. Each accepted sample strobe reads one point of a 64-point sine cycle. The point is read negated when the carrier phase is currently inverted. Outside a reversal the point goes to the output untouched. Around a reversal the point is multiplied by a raised-cosine gain, so the carrier fades to silence, changes phase while silent, and fades back in. This keeps the keying spectrum narrow.

The surrounding logic supplies three inputs. The first is a sample strobe at the carrier sample rate. The second is a mid-bit strobe, issued once per symbol, which is where the next symbol is decided. The third is the value of that next symbol. A zero symbol requests a reversal and a one symbol keeps the phase. The block does not sequence bits itself. The output side is a stream with a valid pulse and no ready: the DAC takes every sample at the strobe rate, so the block has no back-pressure path. `dac_vld` pulses for one clock after each accepted strobe, and `dac_q` holds its value between strobes.

Top module: `psk_shaped_mod`

## Requirements
- R1: While `rst_n` is low and after it is released, `dac_q` is 0x80, `dac_vld` is 0, the table pointer is 0, the phase is not inverted and the carrier is unscaled.
- R2: Each clock with `smp_stb` high produces one sample. `dac_vld` is high in the clock that follows, and the table pointer then advances by one, modulo 64. A clock without `smp_stb` leaves `dac_q` unchanged and `dac_vld` low.
- R3: With no reversal in progress, the sample for pointer i is 0x80 + round(127·sin(2πi/64)), or 0x80 minus that amount when the phase is inverted.
- R4: A `mid_stb` with `next_bit` = 0 schedules a reversal. It starts at the next carrier-cycle boundary, which is the strobe after the one with pointer 63. For the next RAMP (7) carrier cycles, the signed sine point of falling cycle c (c = 0..RAMP-1) is scaled by G[c+1]. Here G[k] = round(255·(1+cos(πk/RAMP))/2).
- R5: In the last falling cycle the gain is G[RAMP] = 0, so every sample in that cycle is exactly 0x80.
- R6: At the boundary that ends the falling ramp, the phase inverts. For the next RAMP cycles, rising cycle c is scaled by G[RAMP-1-c], and after that the carrier is unscaled again.
- R7: A `mid_stb` with `next_bit` = 1 leaves the phase and the amplitude unchanged.
- R8: A zero decision taken during the last rising cycle starts a new falling ramp at the very next boundary, with no unscaled cycle in between.
- R9: A scaled sample is 0x80 + trunc(s·g/256), where s is the signed sine point and g is the gain, and the division rounds toward zero (toward mid-scale).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Sample strobe: produce the next carrier sample |
| mid_stb | input | 1 | Mid-symbol strobe: take the look-ahead decision |
| next_bit | input | 1 | Value of the next symbol, sampled with `mid_stb` |
| dac_q | output | 8 | Offset-binary DAC sample, mid-scale 0x80 |
| dac_vld | output | 1 | One-clock pulse marking a new `dac_q` |

## Verification
The bench drives a symbol sequence that includes single zeros, runs of zeros and runs of ones. It compares every sample against a model built from the gain and sine formulas. A gain index off by one would show up as a nonzero sample in the silent cycle, and a phase swap taken at the wrong boundary would flip the sign of the samples on one side of the gap. Two zeros in a row probe the back-to-back case: a design that inserts an unscaled cycle there would put full amplitude where the ramp should already be falling. Strobe gaps check that the output holds between strobes. Negative products with a remainder catch a design that floors instead of truncating, because it would land one code below mid-scale.

// File: rtl/psk_shape_pkg.sv
package psk_shape_pkg;

  typedef enum logic [1:0] {
    ENV_FULL = 2'd0,
    ENV_FALL = 2'd1,
    ENV_RISE = 2'd2
  } env_state_e;

  localparam real PI_C = 3.14159265358979;

  // Signed sine point, rounded half away from zero.
  function automatic int sine_point(int idx, int pts, int amp);
    real r;
    r = amp * $sin(2.0 * PI_C * idx / pts);
    if (r >= 0.0) return $rtoi(r + 0.5);
    else return -$rtoi(-r + 0.5);
  endfunction

  // Raised-cosine gain, G[0] = full scale, G[ramp] = 0.
  function automatic int gain_point(int k, int ramp, int gmax);
    real r;
    r = gmax * (1.0 + $cos(PI_C * k / ramp)) / 2.0;
    return $rtoi(r + 0.5);
  endfunction

endpackage

// File: rtl/psk_sine_rom.sv
module psk_sine_rom #(
  parameter int PTS   = 64,
  parameter int DAC_W = 8,
  localparam int PTR_W = $clog2(PTS)
) (
  input  logic [PTR_W-1:0]        idx,
  output logic signed [DAC_W-1:0] val
);
  localparam int AMP = 2 ** (DAC_W - 1) - 1;

  logic signed [DAC_W-1:0] tab [PTS];

  for (genvar i = 0; i < PTS; i++) begin : g_pt
    localparam int V = psk_shape_pkg::sine_point(i, PTS, AMP);
    assign tab[i] = DAC_W'(V);
  end

  assign val = tab[idx];
endmodule

// File: rtl/psk_gain_rom.sv
module psk_gain_rom #(
  parameter int RAMP   = 7,
  parameter int GAIN_W = 8,
  localparam int GI_W  = $clog2(RAMP + 1)
) (
  input  logic [GI_W-1:0]   idx,
  output logic [GAIN_W-1:0] val
);
  localparam int GMAX = 2 ** GAIN_W - 1;

  logic [GAIN_W-1:0] tab [RAMP+1];

  for (genvar k = 0; k <= RAMP; k++) begin : g_pt
    localparam int V = psk_shape_pkg::gain_point(k, RAMP, GMAX);
    assign tab[k] = GAIN_W'(V);
  end

  assign val = (int'(idx) <= RAMP) ? tab[idx] : '0;
endmodule

// File: rtl/psk_env_ctrl.sv
module psk_env_ctrl #(
  parameter int PTS  = 64,
  parameter int RAMP = 7,
  localparam int PTR_W = $clog2(PTS),
  localparam int CNT_W = $clog2(RAMP),
  localparam int GI_W  = $clog2(RAMP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_stb,
  input  logic             mid_stb,
  input  logic             next_bit,
  output logic [PTR_W-1:0] ptr,
  output logic             inv,
  output logic             bypass,
  output logic [GI_W-1:0]  gidx
);
  import psk_shape_pkg::*;

  env_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic             pend_q;
  logic             pend_eff;
  logic             wrap;
  logic             take;
  logic             cnt_last;

  assign wrap     = smp_stb && (ptr == PTR_W'(PTS - 1));
  assign cnt_last = (cnt == CNT_W'(RAMP - 1));
  assign pend_eff = mid_stb ? !next_bit : pend_q;
  assign take     = (st == ENV_FULL) || (st == ENV_RISE && cnt_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      inv    <= 1'b0;
      st     <= ENV_FULL;
      cnt    <= '0;
      pend_q <= 1'b0;
    end else begin
      if (smp_stb) ptr <= ptr + 1'b1;
      if (wrap && take) pend_q <= 1'b0;
      else if (mid_stb) pend_q <= !next_bit;
      if (wrap) begin
        unique case (st)
          ENV_FULL: if (pend_eff) begin
            st  <= ENV_FALL;
            cnt <= '0;
          end
          ENV_FALL: if (cnt_last) begin
            inv <= ~inv;
            st  <= ENV_RISE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
          ENV_RISE: if (cnt_last) begin
            st  <= pend_eff ? ENV_FALL : ENV_FULL;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
          default: st <= ENV_FULL;
        endcase
      end
    end
  end

  assign bypass = (st == ENV_FULL);
  assign gidx   = (st == ENV_FALL) ? (GI_W'(cnt) + GI_W'(1))
                                   : (GI_W'(RAMP - 1) - GI_W'(cnt));

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> ptr == $past(ptr) + 1'b1); // R2
  AST_FLIP_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && st == ENV_FALL && cnt_last |=> inv != $past(inv)); // R6
  AST_FLIP_ONLY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrap && st == ENV_FALL && cnt_last) |=> $stable(inv)); // R6
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < RAMP); // R4
endmodule

// File: rtl/psk_scaler.sv
module psk_scaler #(
  parameter int DAC_W  = 8,
  parameter int GAIN_W = 8
) (
  input  logic signed [DAC_W-1:0] s,
  input  logic                    inv,
  input  logic                    bypass,
  input  logic [GAIN_W-1:0]       g,
  output logic [DAC_W-1:0]        code
);
  localparam int PW = DAC_W + GAIN_W + 2;

  logic signed [DAC_W:0]   sp;
  logic signed [PW-1:0]    prod;
  logic [PW-1:0]           mag;
  logic [PW-1:0]           q;
  logic [PW-1:0]           res;
  logic [DAC_W-1:0]        val_s;

  always_comb begin
    sp    = inv ? -{s[DAC_W-1], s} : {s[DAC_W-1], s};
    prod  = PW'(sp) * $signed({2'b00, g});
    mag   = prod[PW-1] ? PW'(-prod) : PW'(prod);
    q     = mag >> GAIN_W;
    res   = prod[PW-1] ? (~q + 1'b1) : q;
    val_s = bypass ? sp[DAC_W-1:0] : res[DAC_W-1:0];
    code  = {~val_s[DAC_W-1], val_s[DAC_W-2:0]};
  end
endmodule

// File: rtl/psk_shaped_mod.sv
module psk_shaped_mod #(
  parameter int PTS    = 64,
  parameter int RAMP   = 7,
  parameter int DAC_W  = 8,
  parameter int GAIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_stb,
  input  logic             mid_stb,
  input  logic             next_bit,
  output logic [DAC_W-1:0] dac_q,
  output logic             dac_vld
);
  localparam int PTR_W = $clog2(PTS);
  localparam int GI_W  = $clog2(RAMP + 1);
  localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};

  logic [PTR_W-1:0]        ptr;
  logic                    inv;
  logic                    bypass;
  logic [GI_W-1:0]         gidx;
  logic signed [DAC_W-1:0] sine_v;
  logic [GAIN_W-1:0]       gain_v;
  logic [DAC_W-1:0]        code;

  psk_env_ctrl #(.PTS(PTS), .RAMP(RAMP)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .mid_stb(mid_stb),
    .next_bit(next_bit), .ptr(ptr), .inv(inv), .bypass(bypass), .gidx(gidx)
  );

  psk_sine_rom #(.PTS(PTS), .DAC_W(DAC_W)) sine_i (.idx(ptr), .val(sine_v));

  psk_gain_rom #(.RAMP(RAMP), .GAIN_W(GAIN_W)) gain_i (.idx(gidx), .val(gain_v));

  psk_scaler #(.DAC_W(DAC_W), .GAIN_W(GAIN_W)) scale_i (
    .s(sine_v), .inv(inv), .bypass(bypass), .g(gain_v), .code(code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_q   <= MID;
      dac_vld <= 1'b0;
    end else begin
      dac_vld <= smp_stb;
      if (smp_stb) dac_q <= code;
    end
  end

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> dac_vld); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> !dac_vld && $stable(dac_q)); // R2
  AST_SILENT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && !bypass && gidx == GI_W'(RAMP) |=> dac_q == MID); // R5
endmodule

// File: tb/psk_shaped_mod_tb_top.sv
module psk_shaped_mod_tb_top;
  localparam int CLK_P = 10;
  localparam int PTS   = 64;
  localparam int RAMP  = 7;
  localparam int NVEC  = 10;
  localparam real PI_T = 3.14159265358979;
  // Each vector: bit1 = symbol decided at mid-bit, bit0 = strobe gaps in this symbol
  localparam logic [1:0] VEC [NVEC] = '{2'b10, 2'b00, 2'b01, 2'b00, 2'b10,
                                        2'b11, 2'b00, 2'b10, 2'b01, 2'b10};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_stb = 1'b0;
  logic       mid_stb = 1'b0;
  logic       next_bit = 1'b0;
  logic [7:0] dac_q;
  logic       dac_vld;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int mph, mst, mcnt;
  bit minv, mpend, m_one, m_b2b;
  int idle_ctr;

  always #(CLK_P/2) clk = ~clk;

  psk_shaped_mod dut_i (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .mid_stb(mid_stb),
    .next_bit(next_bit), .dac_q(dac_q), .dac_vld(dac_vld)
  );

  function automatic int sine_ref(int i);
    real r;
    r = 127.0 * $sin(2.0 * PI_T * i / PTS);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  function automatic int gain_ref(int k);
    return $rtoi(255.0 * (1.0 + $cos(PI_T * k / RAMP)) / 2.0 + 0.5);
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    mph = 0; mst = 0; mcnt = 0; minv = 0; mpend = 0; m_one = 0; m_b2b = 0;
  endtask

  task automatic sample(bit mid, bit nb);
    int s, g, p, expv;
    bit pe, take, wrap;
    string tag;
    s = sine_ref(mph);
    if (minv) s = -s;
    tag = m_one ? "R7" : "R3";
    if (mst == 0) expv = 128 + s;
    else begin
      g = (mst == 1) ? gain_ref(mcnt + 1) : gain_ref(RAMP - 1 - mcnt);
      p = s * g;
      expv = 128 + p / 256;
      if (mst == 1 && mcnt == RAMP - 1) tag = "R5";
      else if (mst == 1 && m_b2b) tag = "R8";
      else if (p < 0 && (p % 256) != 0) tag = "R9";
      else tag = (mst == 1) ? "R4" : "R6";
    end
    @(negedge clk);
    smp_stb = 1'b1; mid_stb = mid; next_bit = nb;
    @(posedge clk);
    @(negedge clk);
    smp_stb = 1'b0; mid_stb = 1'b0;
    check(tag, dac_q, 8'(expv));
    check("R2", {7'd0, dac_vld}, 8'd1);
    pe   = mid ? !nb : mpend;
    wrap = (mph == PTS - 1);
    take = (mst == 0) || (mst == 2 && mcnt == RAMP - 1);
    if (mid) m_one = nb;
    if (wrap) begin
      m_b2b = 0;
      case (mst)
        0: if (pe) begin mst = 1; mcnt = 0; end
        1: if (mcnt == RAMP - 1) begin minv = !minv; mst = 2; mcnt = 0; end
           else mcnt++;
        default: if (mcnt == RAMP - 1) begin
             if (pe) begin mst = 1; m_b2b = 1; end else mst = 0;
             mcnt = 0;
           end else mcnt++;
      endcase
    end
    if (wrap && take) mpend = 0;
    else if (mid) mpend = !nb;
    mph = (mph + 1) % PTS;
  endtask

  task automatic idle();
    logic [7:0] prev;
    prev = dac_q;
    @(negedge clk);
    smp_stb = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R2", dac_q, prev);
    check("R2", {7'd0, dac_vld}, 8'd0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    idle_ctr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", dac_q, 8'h80);
    check("R1", {7'd0, dac_vld}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", dac_q, 8'h80);

    for (int k = 0; k < NVEC; k++) begin
      for (int c = 0; c < 2 * RAMP; c++) begin
        for (int p = 0; p < PTS; p++) begin
          if (VEC[k][0]) begin
            idle_ctr++;
            if (idle_ctr % 3 == 0) idle();
          end
          sample(c == RAMP - 1 && p == PTS / 2, VEC[k][1]);
        end
      end
    end

    // R1: reset in the middle of a falling ramp
    for (int p = 0; p < PTS * (RAMP + 3); p++)
      sample(p == 5, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1", dac_q, 8'h80);
    check("R1", {7'd0, dac_vld}, 8'd0);
    rst_n = 1'b1;
    model_reset();
    // R3: first samples after reset are unscaled and not inverted
    for (int p = 0; p < PTS; p++) sample(1'b0, 1'b1);
    // R9: explicit truncation point, s=-12, gain G[6]=13 -> 0x80, not 0x7F
    for (int p = 0; p < PTS * (RAMP + RAMP - 1); p++) sample(p == 3, 1'b0);
    for (int p = 0; p < 33; p++) sample(1'b0, 1'b1);
    check("R9", 8'(128 + (-12 * 13) / 256), 8'h80);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule